// File: doc/BRIEF.md
# Multi-Phase Instruction Control Sequencer

This block is the control state machine of a small 16-bit processor. Every instruction is carried through either two or three phases. Phase 0 fetches the opcode word. Phase 1 is present only when the opcode asks for a second word, and it fetches that constant. Phase 2 executes the instruction. From the phase, the opcode held in its own instruction register and a zero flag on the Ra operand, the sequencer drives the datapath controls:

- the instruction-register and constant-register load enables;
- the program-counter load and its source select;
- the register-file and memory write enables;
- the interrupt-flag write.

The block also handles a synchronous reset and one level of interrupt. A request is taken only in phase 0 while no interrupt is already being serviced. When it is taken, the current PC is saved into register 6 and the PC is steered to the interrupt vector. A return strobe, given during phase 2, clears the in-service flag again. A phase-0 indicator tells external interrupt sources when a request will be looked at. The sequencer does no arithmetic itself; the datapath forms all addresses and results.

Top module: `phase_sequencer`

## Requirements
- R1: While `rst` is high, `next_phase` is 0 and both write enables, `ifw`, `ir_load` and `const_load` are 0. `pc_load` is 1 with `pc_sel` = 3 (reset vector). After the clock edge, `phase` is 0 and `irq_flag` is 0.
- R2: In phase 0 with no interrupt taken and opcode bit 10 clear, `ir_load` is 1, `next_phase` is 2 and `pc_load` is 0.
- R3: In phase 0 with no interrupt taken and opcode bit 10 set, `ir_load` is 1, `next_phase` is 1, `pc_load` is 1 and `pc_sel` is 0 (PC+1).
- R4: In phase 1, `const_load` is 1, `ir_load` is 0, `pc_load` is 0 and `next_phase` is 2.
- R5: In phase 2, `next_phase` is 0 and `pc_load` is 1. `pc_sel` is 1 (jump target) for a taken control-transfer operation and 0 otherwise. Control-transfer operations are: sub-op 2 (always taken), sub-op 3 (taken when `ra_zero` is 1) and sub-op 4 (taken when `ra_zero` is 0).
- R6: An interrupt is taken when `irq` is high, `rst` is low, `irq_flag` is 0 and the phase is 0. In that cycle:
  - `ifw` is 1 and `reg_we` is 1 with `reg_waddr` = 6;
  - `pc_load` is 1 with `pc_sel` = 2 (interrupt vector);
  - `ir_load` is 0 and `next_phase` is 0.
  `irq_flag` is 1 after the edge.
- R7: `irq` has no effect on any output or on `irq_flag` when `irq_flag` is 1, when the phase is not 0, or when `rst` is high.
- R8: `rti_clr` high in phase 2 clears `irq_flag` at that clock edge. In any other phase it is ignored, and reset takes priority over it.
- R9: `phase0` is 1 exactly when `phase` is 0.
- R10: The decode fields come from the held instruction word:
  - `alu_fn` = bits 15..11;
  - `alu_op` = 1 when bit 9 is clear;
  - `rb_idx` = bits 8..6, `rc_idx` = bits 5..3, `ra_idx` = bits 2..0.
  When bit 9 is set, bits 8..6 are the sub-op.
- R11: `mem_we` is 1 only in phase 2 for sub-op 1 (store). `reg_we` with `reg_waddr` = Rc is 1 only in phase 2, for ALU operations and for sub-ops 0 (load), 5 (PC-relative load), 2, 3 and 4. Sub-ops 6 and 7 write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq | input | 1 | Interrupt request |
| rti_clr | input | 1 | Return-from-interrupt flag clear strobe |
| ra_zero | input | 1 | Ra operand equals zero |
| opcode | input | 16 | Word read from memory at the PC |
| phase | output | 2 | Current phase |
| next_phase | output | 2 | Phase after the next edge |
| phase0 | output | 1 | High during phase 0 |
| ir_load | output | 1 | Instruction register load enable |
| const_load | output | 1 | Constant register load enable |
| pc_load | output | 1 | PC register update enable |
| pc_sel | output | 2 | PC source: 0 PC+1, 1 target, 2 interrupt vector, 3 reset vector |
| reg_we | output | 1 | Register file write enable |
| reg_waddr | output | 3 | Register file write index |
| mem_we | output | 1 | Memory write enable |
| ifw | output | 1 | Interrupt flag write |
| irq_flag | output | 1 | Interrupt in service |
| alu_fn | output | 5 | ALU function code |
| alu_op | output | 1 | Held instruction is an ALU operation |
| ra_idx | output | 3 | Ra index |
| rb_idx | output | 3 | Rb index |
| rc_idx | output | 3 | Rc index |

## Verification
A phase register that slips shows at the ports in the same cycle. `next_phase`, `const_load`, `ir_load` and `phase0` all follow the phase combinationally, so a skipped or repeated phase is visible at once. A wrong held instruction word shows in the decode fields as soon as it is loaded, and in the write enables and `pc_sel` in the next phase 2. A stale or missing interrupt flag shows one cycle later, when a new request is wrongly taken or wrongly refused in phase 0.

// File: rtl/phase_sequencer.sv
module phase_sequencer (
  input  logic        clk,
  input  logic        rst,
  input  logic        irq,
  input  logic        rti_clr,
  input  logic        ra_zero,
  input  logic [15:0] opcode,
  output logic [1:0]  phase,
  output logic [1:0]  next_phase,
  output logic        phase0,
  output logic        ir_load,
  output logic        const_load,
  output logic        pc_load,
  output logic [1:0]  pc_sel,
  output logic        reg_we,
  output logic [2:0]  reg_waddr,
  output logic        mem_we,
  output logic        ifw,
  output logic        irq_flag,
  output logic [4:0]  alu_fn,
  output logic        alu_op,
  output logic [2:0]  ra_idx,
  output logic [2:0]  rb_idx,
  output logic [2:0]  rc_idx
);
  localparam logic [2:0] SUB_LD  = 3'd0;
  localparam logic [2:0] SUB_ST  = 3'd1;
  localparam logic [2:0] SUB_JMP = 3'd2;
  localparam logic [2:0] SUB_BEQ = 3'd3;
  localparam logic [2:0] SUB_BNE = 3'd4;
  localparam logic [2:0] SUB_LDR = 3'd5;
  localparam logic [1:0] SEL_INC = 2'd0;
  localparam logic [1:0] SEL_TGT = 2'd1;
  localparam logic [1:0] SEL_IRQ = 2'd2;
  localparam logic [1:0] SEL_RST = 2'd3;
  localparam logic [2:0] SAVE_REG = 3'd6;

  logic [1:0]  ph_q;
  logic        flag_q;
  logic [15:0] ir_q;

  wire       need_const = opcode[10];
  wire       taking_irq = !rst && irq && !flag_q && (ph_q == 2'd0);
  wire       executing  = !rst && (ph_q == 2'd2);
  wire [2:0] sub_op     = ir_q[8:6];
  wire       is_alu     = !ir_q[9];
  wire       taken      = !is_alu && ((sub_op == SUB_JMP) ||
                                      (sub_op == SUB_BEQ && ra_zero) ||
                                      (sub_op == SUB_BNE && !ra_zero));
  wire       writes_rc  = is_alu || sub_op inside {SUB_LD, SUB_LDR, SUB_JMP, SUB_BEQ, SUB_BNE};

  always_comb begin
    next_phase = 2'd0;
    pc_load    = 1'b0;
    pc_sel     = SEL_INC;
    if (rst) begin
      pc_load = 1'b1;
      pc_sel  = SEL_RST;
    end else if (taking_irq) begin
      pc_load = 1'b1;
      pc_sel  = SEL_IRQ;
    end else begin
      case (ph_q)
        2'd0: begin
          next_phase = need_const ? 2'd1 : 2'd2;
          pc_load    = need_const;
        end
        2'd1: next_phase = 2'd2;
        2'd2: begin
          pc_load = 1'b1;
          pc_sel  = taken ? SEL_TGT : SEL_INC;
        end
        default: next_phase = 2'd0;
      endcase
    end
  end

  assign ir_load    = !rst && (ph_q == 2'd0) && !taking_irq;
  assign const_load = !rst && (ph_q == 2'd1);
  assign ifw        = taking_irq;
  assign reg_we     = taking_irq || (executing && writes_rc);
  assign reg_waddr  = taking_irq ? SAVE_REG : ir_q[5:3];
  assign mem_we     = executing && !is_alu && (sub_op == SUB_ST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= 2'd0;
      flag_q <= 1'b0;
      ir_q   <= '0;
    end else begin
      ph_q <= next_phase;
      if (ir_load) ir_q <= opcode;
      if (taking_irq) flag_q <= 1'b1;
      else if (executing && rti_clr) flag_q <= 1'b0;
    end
  end

  assign phase    = ph_q;
  assign phase0   = (ph_q == 2'd0);
  assign irq_flag = flag_q;
  assign alu_fn   = ir_q[15:11];
  assign alu_op   = is_alu;
  assign rb_idx   = ir_q[8:6];
  assign rc_idx   = ir_q[5:3];
  assign ra_idx   = ir_q[2:0];
endmodule

module phase_sequencer_chk (
  input logic       clk,
  input logic       rst,
  input logic       irq,
  input logic       rti_clr,
  input logic [1:0] phase,
  input logic       mem_we,
  input logic       ifw,
  input logic       irq_flag
);
  assert_reset_R1: assert property (@(posedge clk) rst |=> (phase == 2'd0 && !irq_flag));
  assert_const_to_exec_R4: assert property (@(posedge clk) disable iff (rst) phase == 2'd1 |=> phase == 2'd2);
  assert_exec_to_fetch_R5: assert property (@(posedge clk) disable iff (rst) phase == 2'd2 |=> phase == 2'd0);
  assert_flag_set_R6: assert property (@(posedge clk) disable iff (rst) ifw |=> irq_flag);
  assert_irq_ignored_R7: assert property (@(posedge clk) disable iff (rst) (irq && (irq_flag || phase != 2'd0)) |-> !ifw);
  assert_rti_clears_R8: assert property (@(posedge clk) disable iff (rst) (phase == 2'd2 && rti_clr) |=> !irq_flag);
  assert_store_in_exec_R11: assert property (@(posedge clk) disable iff (rst) mem_we |-> phase == 2'd2);
endmodule

bind phase_sequencer phase_sequencer_chk u_chk (
  .clk(clk), .rst(rst), .irq(irq), .rti_clr(rti_clr), .phase(phase),
  .mem_we(mem_we), .ifw(ifw), .irq_flag(irq_flag)
);

// File: tb/phase_sequencer_test.sv
module phase_sequencer_test;
  logic clk = 1'b0;
  logic rst = 1'b1, irq = 1'b0, rti_clr = 1'b0, ra_zero = 1'b0;
  logic [15:0] opcode = '0;
  logic [1:0] phase, next_phase, pc_sel;
  logic phase0, ir_load, const_load, pc_load, reg_we, mem_we, ifw, irq_flag, alu_op;
  logic [2:0] reg_waddr, ra_idx, rb_idx, rc_idx;
  logic [4:0] alu_fn;

  int runs = 0, fails = 0;
  bit done = 0;

  int m_phase = 0;
  bit m_flag = 0;
  int m_ir = 0;

  always #2.5 clk = ~clk;

  phase_sequencer uut (.*);

  task automatic chk(string req, string what, int act, int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(bit r, bit q, bit rc, bit z, logic [15:0] op);
    int e_next, e_pcl, e_sel, e_irl, e_cl, e_we, e_wa, e_mwe, e_ifw, sub;
    bit acc, alu, tk;
    string tag;
    @(negedge clk);
    rst = r; irq = q; rti_clr = rc; ra_zero = z; opcode = op;
    #1;
    acc = !r && q && !m_flag && m_phase == 0;
    alu = ((m_ir >> 9) & 1) == 0;
    sub = (m_ir >> 6) & 7;
    tk  = !alu && (sub == 2 || (sub == 3 && z) || (sub == 4 && !z));
    e_next = 0; e_pcl = 0; e_sel = 0; e_irl = 0; e_cl = 0; e_we = 0; e_wa = (m_ir >> 3) & 7; e_mwe = 0; e_ifw = 0;
    if (r) begin
      tag = "R1"; e_pcl = 1; e_sel = 3;
    end else if (acc) begin
      tag = "R6"; e_pcl = 1; e_sel = 2; e_ifw = 1; e_we = 1; e_wa = 6;
    end else if (m_phase == 0) begin
      tag = op[10] ? "R3" : "R2";
      e_irl = 1; e_next = op[10] ? 1 : 2; e_pcl = op[10];
    end else if (m_phase == 1) begin
      tag = "R4"; e_cl = 1; e_next = 2;
    end else begin
      tag = "R5"; e_pcl = 1; e_sel = tk ? 1 : 0;
      e_we = alu || sub == 0 || sub == 5 || sub == 2 || sub == 3 || sub == 4;
      e_mwe = !alu && sub == 1;
    end
    if (q && !acc && !r) tag = "R7";
    chk(tag, "phase", phase, m_phase);
    chk(tag, "next_phase", next_phase, e_next);
    chk(tag, "pc_load", pc_load, e_pcl);
    chk(tag, "pc_sel", pc_sel, e_sel);
    chk(tag, "ir_load", ir_load, e_irl);
    chk(tag, "const_load", const_load, e_cl);
    chk(tag, "ifw", ifw, e_ifw);
    chk("R11", "reg_we", reg_we, e_we);
    if (e_we) chk("R11", "reg_waddr", reg_waddr, e_wa);
    chk("R11", "mem_we", mem_we, e_mwe);
    chk("R8", "irq_flag", irq_flag, m_flag);
    chk("R9", "phase0", phase0, m_phase == 0);
    chk("R10", "alu_fn", alu_fn, (m_ir >> 11) & 31);
    chk("R10", "alu_op", alu_op, alu);
    chk("R10", "ra_idx", ra_idx, m_ir & 7);
    chk("R10", "rb_idx", rb_idx, (m_ir >> 6) & 7);
    chk("R10", "rc_idx", rc_idx, (m_ir >> 3) & 7);
    @(posedge clk);
    if (r) begin
      m_phase = 0; m_flag = 0; m_ir = 0;
    end else begin
      if (acc) m_flag = 1;
      else if (m_phase == 2 && rc) m_flag = 0;
      if (e_irl) m_ir = op;
      m_phase = e_next;
    end
  endtask

  initial begin
    step(1, 1, 1, 0, 16'hFFFF);
    step(1, 0, 0, 0, 16'h0000);
    // R2: two-phase ALU op, R11 writes Rc
    step(0, 0, 0, 0, 16'b10101_0_0_011_010_001);
    step(0, 0, 0, 0, 16'h0000);
    // R3/R4: store with constant
    step(0, 0, 0, 0, 16'b00000_1_1_001_100_010);
    step(0, 0, 0, 0, 16'h1234);
    step(0, 0, 0, 0, 16'h0000);
    // R5: BEQ taken and not taken
    step(0, 0, 0, 0, 16'b00000_1_1_011_111_000);
    step(0, 0, 0, 0, 16'h0000);
    step(0, 0, 0, 1, 16'h0000);
    step(0, 0, 0, 0, 16'b00000_1_1_011_111_000);
    step(0, 0, 0, 0, 16'h0000);
    step(0, 0, 0, 0, 16'h0000);
    // R6 accept, then R7 ignored while flag set
    step(0, 1, 0, 0, 16'h0000);
    step(0, 1, 0, 0, 16'b00000_1_1_100_001_000);
    step(0, 1, 0, 0, 16'h0000);
    step(0, 1, 1, 1, 16'h0000);
    // R8: flag cleared by return strobe in phase 2 only
    step(0, 0, 1, 0, 16'b00000_0_1_000_000_000);
    step(0, 0, 0, 0, 16'h0000);
    // R1 priority over R8 and R6
    step(0, 1, 0, 0, 16'h0000);
    step(1, 1, 1, 0, 16'h0000);
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] w = 16'($urandom);
      step(($urandom % 97) == 0, ($urandom % 5) == 0, ($urandom % 3) == 0, $urandom % 2, w);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #(5 * 50000);
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule